// File: doc/BRIEF.md
# Power-up configuration bank loader

This block brings a device's operating registers up from non-volatile storage. At the first clock after reset it samples a strap input once and holds the result as the operating mode for the rest of the run. When the strap is high, the device runs in hardware-select mode: two select pins name one of four stored configuration banks. When the strap is low, the device runs in host mode: the same two pins belong to a serial host bus, and a preset default-bank input names the bank. The chosen bank is then copied one byte per clock into a volatile register file. The whole flattened register file drives the rest of the device.

In host mode the host may read and write the volatile registers through a simple port. It may also order a fresh copy from any of the four banks at run time. The store is external and is read combinationally through a bank/address/data port. A busy flag covers every cycle in which a copy is pending or running. A one-cycle done pulse marks the end of each copy.

Top module: `cfg_bank_loader`

## Requirements
- R1: The strap is sampled once, at the first rising edge after reset release. `host_mode_o` is then the inverse of the sampled strap (1 = host mode), and later strap changes have no effect on it.
- R2: With the strap high, the power-up bank index is `{sel_i[1], sel_i[0]}` as sampled at that first edge. Select pin changes after that edge have no effect on the registers.
- R3: With the strap low, the power-up bank index is `dflt_bank_i` as sampled at that first edge.
- R4: A copy writes register k from bank address k, one byte per clock, for k from 0 to 15 in ascending order. After a power-up load, `busy_o` is high from reset through the 17th rising edge after reset release and falls at that edge. The file then equals the chosen bank.
- R5: `done_o` is high for exactly one cycle: the cycle right after the last byte of a copy is written.
- R6: In host mode, while not busy, a host write updates the addressed register at the next rising edge. `host_rdata_o` combinationally returns the addressed register.
- R7: A host write presented while `busy_o` is high is dropped and leaves the register file unchanged.
- R8: In hardware-select mode, host writes are dropped and `host_rdata_o` reads 0.
- R9: In host mode, while not busy, a `reload_i` pulse starts a copy from `reload_bank_i`. `busy_o` rises at the next rising edge, and `done_o` follows 16 edges after that.
- R10: In hardware-select mode, `reload_i` is ignored: `busy_o` stays low and the registers are unchanged.
- R11: A `reload_i` that arrives while a copy is running is ignored, and the running copy completes from its own bank.
- R12: Register k appears on `cfg_o[8k+7:8k]`, and its reset value is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset (power-up) |
| strap_i | input | 1 | Mode strap, 1 = hardware select, 0 = host mode |
| sel_i | input | 2 | Bank select pins (serial bus pins in host mode) |
| dflt_bank_i | input | 2 | Preset power-up bank for host mode |
| nvm_bank_o | output | 2 | Bank index presented to the store |
| nvm_addr_o | output | 4 | Byte address presented to the store |
| nvm_data_i | input | 8 | Store read data for bank/address |
| host_we_i | input | 1 | Host write strobe |
| host_addr_i | input | 4 | Host register address |
| host_wdata_i | input | 8 | Host write data |
| host_rdata_o | output | 8 | Host read data |
| reload_i | input | 1 | Host reload command |
| reload_bank_i | input | 2 | Bank to reload from |
| host_mode_o | output | 1 | Latched mode, 1 = host mode |
| busy_o | output | 1 | Copy pending or in progress |
| done_o | output | 1 | One-cycle copy-complete pulse |
| cfg_o | output | 128 | Flattened volatile register file |

## Verification
The power-up load completes 17 edges after reset release. A reload completes 16 edges after the edge that captures the command. A host write is visible at the following edge, and reads are combinational. The bench drives every input on the falling edge. It counts falling edges from the stimulus and compares `busy_o` and `done_o` against those exact counts. It reads registers only half a period after the edge that should have updated them. Writes and reloads injected in the middle of a copy are checked after the done pulse, when the file must match the bank alone.

// File: rtl/cbl_pkg.sv
package cbl_pkg;
   typedef enum logic [1:0] {
      ST_LATCH = 2'd0,
      ST_COPY  = 2'd1,
      ST_IDLE  = 2'd2
   } ld_state_e;
endpackage

// File: rtl/cbl_mode_latch.sv
module cbl_mode_latch #(
   parameter int SEL_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             capture_i,
   input  logic             strap_i,
   input  logic [SEL_W-1:0] sel_i,
   input  logic [SEL_W-1:0] dflt_i,
   output logic             host_mode_o,
   output logic [SEL_W-1:0] pick_bank_o
);
   logic latched_q;
   logic host_q;

   // live bank choice, consumed by the sequencer only in its capture state
   assign pick_bank_o = strap_i ? sel_i : dflt_i;
   assign host_mode_o = host_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         latched_q <= 1'b0;
         host_q    <= 1'b0;
      end else if (capture_i && !latched_q) begin
         latched_q <= 1'b1;
         host_q    <= !strap_i;
      end
   end

   // R1: once captured, the mode never moves again
   a_r1_mode_held: assert property (@(posedge clk) disable iff (!rst_n)
      latched_q |=> ($stable(host_q) && latched_q));
endmodule

// File: rtl/cbl_copy_seq.sv
module cbl_copy_seq
   import cbl_pkg::*;
#(
   parameter int ADDR_W = 4,
   parameter int SEL_W  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_mode_i,
   input  logic [SEL_W-1:0]  pick_bank_i,
   input  logic              reload_i,
   input  logic [SEL_W-1:0]  reload_bank_i,
   output logic              capture_o,
   output logic              busy_o,
   output logic              done_o,
   output logic              copy_we_o,
   output logic [ADDR_W-1:0] addr_o,
   output logic [SEL_W-1:0]  bank_o
);
   localparam logic [ADDR_W-1:0] LAST_ADDR = {ADDR_W{1'b1}};

   ld_state_e         state_q;
   logic [ADDR_W-1:0] addr_q;
   logic [SEL_W-1:0]  bank_q;
   logic              done_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_LATCH;
         addr_q  <= '0;
         bank_q  <= '0;
         done_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         unique case (state_q)
            ST_LATCH: begin
               bank_q  <= pick_bank_i;
               addr_q  <= '0;
               state_q <= ST_COPY;
            end
            ST_COPY: begin
               addr_q <= addr_q + 1'b1;
               if (addr_q == LAST_ADDR) begin
                  state_q <= ST_IDLE;
                  done_q  <= 1'b1;
               end
            end
            ST_IDLE: begin
               if (reload_i && host_mode_i) begin
                  bank_q  <= reload_bank_i;
                  addr_q  <= '0;
                  state_q <= ST_COPY;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign capture_o = (state_q == ST_LATCH);
   assign busy_o    = (state_q != ST_IDLE);
   assign copy_we_o = (state_q == ST_COPY);
   assign done_o    = done_q;
   assign addr_o    = addr_q;
   assign bank_o    = bank_q;

   // R4: addresses advance by one per clock during a copy
   a_r4_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_COPY && addr_q != LAST_ADDR) |=>
      (addr_q == $past(addr_q) + 1'b1));
   // R5: done is a single-cycle pulse that follows a copy
   a_r5_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);
   a_r5_done_after_copy: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done_o) |-> $past(state_q == ST_COPY));
   // R10: hardware-select mode never leaves idle
   a_r10_hw_reload_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_IDLE && !host_mode_i) |=> (state_q == ST_IDLE));
   // R11: a running copy keeps its bank to the end
   a_r11_bank_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_COPY && addr_q != LAST_ADDR) |=>
      ($stable(bank_q) && state_q == ST_COPY));
endmodule

// File: rtl/cbl_regfile.sv
module cbl_regfile #(
   parameter int DATA_W = 8,
   parameter int ADDR_W = 4,
   parameter int NREGS  = 16
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    copy_we_i,
   input  logic [ADDR_W-1:0]       copy_addr_i,
   input  logic [DATA_W-1:0]       copy_data_i,
   input  logic                    host_mode_i,
   input  logic                    busy_i,
   input  logic                    host_we_i,
   input  logic [ADDR_W-1:0]       host_addr_i,
   input  logic [DATA_W-1:0]       host_wdata_i,
   output logic [DATA_W-1:0]       host_rdata_o,
   output logic [NREGS*DATA_W-1:0] cfg_o
);
   logic host_ok;
   assign host_ok = host_we_i && host_mode_i && !busy_i;

   for (genvar k = 0; k < NREGS; k++) begin : g_reg
      logic [DATA_W-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            q <= '0;
         else if (copy_we_i && copy_addr_i == ADDR_W'(k))
            q <= copy_data_i;
         else if (host_ok && host_addr_i == ADDR_W'(k))
            q <= host_wdata_i;
      end
      assign cfg_o[k*DATA_W +: DATA_W] = q;
   end

   always_comb begin
      host_rdata_o = '0;
      if (host_mode_i) begin
         for (int k = 0; k < NREGS; k++)
            if (host_addr_i == ADDR_W'(k))
               host_rdata_o = cfg_o[k*DATA_W +: DATA_W];
      end
   end

   // R7: while busy and not copying, nothing may change the file
   a_r7_busy_blocks_host: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_i && !copy_we_i) |=> $stable(cfg_o));
   // R8: in hardware-select mode only the copy engine writes
   a_r8_hw_no_host_write: assert property (@(posedge clk) disable iff (!rst_n)
      (!host_mode_i && !copy_we_i) |=> $stable(cfg_o));
   // R8: reads in hardware-select mode are zero
   a_r8_hw_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !host_mode_i |-> (host_rdata_o == '0));
endmodule

// File: rtl/cfg_bank_loader.sv
module cfg_bank_loader #(
   parameter int DATA_W = 8,
   parameter int ADDR_W = 4,
   parameter int SEL_W  = 2
) (
   input  logic                                clk,
   input  logic                                rst_n,
   input  logic                                strap_i,
   input  logic [SEL_W-1:0]                    sel_i,
   input  logic [SEL_W-1:0]                    dflt_bank_i,
   output logic [SEL_W-1:0]                    nvm_bank_o,
   output logic [ADDR_W-1:0]                   nvm_addr_o,
   input  logic [DATA_W-1:0]                   nvm_data_i,
   input  logic                                host_we_i,
   input  logic [ADDR_W-1:0]                   host_addr_i,
   input  logic [DATA_W-1:0]                   host_wdata_i,
   output logic [DATA_W-1:0]                   host_rdata_o,
   input  logic                                reload_i,
   input  logic [SEL_W-1:0]                    reload_bank_i,
   output logic                                host_mode_o,
   output logic                                busy_o,
   output logic                                done_o,
   output logic [(DATA_W<<ADDR_W)-1:0]         cfg_o
);
   localparam int NREGS     = 1 << ADDR_W;
   localparam int NUM_BANKS = 1 << SEL_W;

   if (DATA_W < 1) begin : g_bad_data_w
      $error("DATA_W must be at least 1");
   end
   if (ADDR_W < 1 || ADDR_W > 8) begin : g_bad_addr_w
      $error("ADDR_W must lie in 1..8");
   end
   if (NUM_BANKS < 2) begin : g_bad_sel_w
      $error("SEL_W must give at least two banks");
   end

   logic             capture;
   logic             copy_we;
   logic [SEL_W-1:0] pick_bank;

   cbl_mode_latch #(.SEL_W(SEL_W)) i_mode (
      .clk         (clk),
      .rst_n       (rst_n),
      .capture_i   (capture),
      .strap_i     (strap_i),
      .sel_i       (sel_i),
      .dflt_i      (dflt_bank_i),
      .host_mode_o (host_mode_o),
      .pick_bank_o (pick_bank)
   );

   cbl_copy_seq #(.ADDR_W(ADDR_W), .SEL_W(SEL_W)) i_seq (
      .clk           (clk),
      .rst_n         (rst_n),
      .host_mode_i   (host_mode_o),
      .pick_bank_i   (pick_bank),
      .reload_i      (reload_i),
      .reload_bank_i (reload_bank_i),
      .capture_o     (capture),
      .busy_o        (busy_o),
      .done_o        (done_o),
      .copy_we_o     (copy_we),
      .addr_o        (nvm_addr_o),
      .bank_o        (nvm_bank_o)
   );

   cbl_regfile #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .NREGS(NREGS)) i_rf (
      .clk          (clk),
      .rst_n        (rst_n),
      .copy_we_i    (copy_we),
      .copy_addr_i  (nvm_addr_o),
      .copy_data_i  (nvm_data_i),
      .host_mode_i  (host_mode_o),
      .busy_i       (busy_o),
      .host_we_i    (host_we_i),
      .host_addr_i  (host_addr_i),
      .host_wdata_i (host_wdata_i),
      .host_rdata_o (host_rdata_o),
      .cfg_o        (cfg_o)
   );

   // R9: a host-mode reload while idle makes busy rise at the next edge
   a_r9_reload_starts: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && reload_i && host_mode_o) |=> busy_o);
endmodule

// File: tb/test_cfg_bank_loader.sv
`timescale 1ns/1ps
module test_cfg_bank_loader;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         strap = 1'b1;
   logic [1:0]   sel = '0, dflt = '0, nvm_bank, rl_bank = '0;
   logic [3:0]   nvm_addr, h_addr = '0;
   logic [7:0]   nvm_data, h_wdata = '0, h_rdata;
   logic         h_we = 1'b0, reload = 1'b0, host_mode, busy, done;
   logic [127:0] cfg;

   int tests = 0;
   int fails = 0;
   bit finished = 1'b0;
   logic [7:0] model [16];

   always #4 clk = ~clk;

   function automatic logic [7:0] nvm_val(input int b, input int a);
      return 8'((b * 53 + a * 29 + 17) ^ (b << 5));
   endfunction

   assign nvm_data = nvm_val(int'(nvm_bank), int'(nvm_addr));

   cfg_bank_loader i_cfg_bank_loader (
      .clk(clk), .rst_n(rst_n), .strap_i(strap), .sel_i(sel),
      .dflt_bank_i(dflt), .nvm_bank_o(nvm_bank), .nvm_addr_o(nvm_addr),
      .nvm_data_i(nvm_data), .host_we_i(h_we), .host_addr_i(h_addr),
      .host_wdata_i(h_wdata), .host_rdata_o(h_rdata), .reload_i(reload),
      .reload_bank_i(rl_bank), .host_mode_o(host_mode), .busy_o(busy),
      .done_o(done), .cfg_o(cfg)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   function automatic int cfg_mismatch();
      int n = 0;
      for (int k = 0; k < 16; k++)
         if (cfg[k*8 +: 8] !== model[k]) n++;
      return n;
   endfunction

   task automatic load_model(input int b);
      for (int k = 0; k < 16; k++) model[k] = nvm_val(b, k);
   endtask

   // counts falling edges until done; the first negedge follows the start edge
   task automatic run_copy(input string req, input int b, input bit inject);
      int cnt = 0;
      int busy_bad = 0;
      forever begin
         @(negedge clk);
         cnt++;
         if (cnt == 1) reload = 1'b0;
         if (inject && cnt == 5) begin
            h_we = 1'b1; h_addr = 4'd0; h_wdata = ~nvm_val(b, 0);
            reload = 1'b1; rl_bank = 2'(b + 1);
         end
         if (inject && cnt == 6) begin
            h_we = 1'b0; reload = 1'b0;
         end
         if (done || cnt > 40) break;
         if (busy !== 1'b1) busy_bad++;
      end
      chk({req, " copy length"}, cnt, 17);
      chk({req, " busy through copy"}, busy_bad, 0);
      chk({req, " busy low at done"}, busy, 0);
      load_model(b);
      chk({req, " file equals bank"}, cfg_mismatch(), 0);
      @(negedge clk);
      chk("R5 done single cycle", done, 0);
   endtask

   task automatic power_up(input logic s, input logic [1:0] sl, input logic [1:0] d, input int b, input string req);
      @(negedge clk);
      rst_n = 1'b0; strap = s; sel = sl; dflt = d;
      repeat (3) @(negedge clk);
      chk("R12 reset cfg zero", cfg, 0);
      chk("R5 no done in reset", done, 0);
      rst_n = 1'b1;
      run_copy(req, b, 1'b0);
      chk("R1 mode from strap", host_mode, !s);
   endtask

   task automatic host_write(input logic [3:0] a, input logic [7:0] d);
      h_we = 1'b1; h_addr = a; h_wdata = d;
      @(negedge clk);
      h_we = 1'b0;
   endtask

   task automatic host_read(input logic [3:0] a, input logic [7:0] exp, input string req);
      h_addr = a;
      #1;
      chk(req, h_rdata, exp);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd1234));
      // hardware-select mode, bank 2 from pins
      power_up(1'b1, 2'd2, 2'd1, 2, "R2 R4 hw bank from pins");
      strap = 1'b0; sel = 2'd3;
      repeat (3) @(negedge clk);
      chk("R1 strap change ignored", host_mode, 0);
      chk("R2 pin change ignored", cfg_mismatch(), 0);
      for (int k = 0; k < 16; k++)
         chk("R12 byte lane", cfg[k*8 +: 8], nvm_val(2, k));
      host_write(4'd3, ~nvm_val(2, 3));
      chk("R8 hw write dropped", cfg_mismatch(), 0);
      host_read(4'd3, 8'h00, "R8 hw read zero");
      reload = 1'b1; rl_bank = 2'd1;
      @(negedge clk);
      reload = 1'b0;
      chk("R10 hw reload no busy", busy, 0);
      repeat (4) @(negedge clk);
      chk("R10 hw reload no change", cfg_mismatch(), 0);

      // host mode, default bank 0 then 3
      power_up(1'b0, 2'd3, 2'd0, 0, "R3 host default bank 0");
      power_up(1'b0, 2'd1, 2'd3, 3, "R3 host preset bank 3");
      sel = 2'd2;
      host_read(4'd5, nvm_val(3, 5), "R6 host read");

      // random host traffic
      for (int i = 0; i < 300; i++) begin
         int op = $urandom_range(0, 9);
         logic [3:0] a = 4'($urandom_range(0, 15));
         logic [7:0] d = 8'($urandom_range(0, 255));
         if (op <= 4) begin
            host_write(a, d);
            model[a] = d;
            host_read(a, d, "R6 write then read");
         end else if (op <= 8) begin
            host_read(a, model[a], "R6 random read");
            @(negedge clk);
         end else begin
            int b = $urandom_range(0, 3);
            reload = 1'b1; rl_bank = 2'(b);
            run_copy("R9 R7 R11 reload", b, 1'b1);
            host_read(4'd0, nvm_val(b, 0), "R7 busy write dropped");
         end
      end
      chk("R12 file matches model", cfg_mismatch(), 0);

      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule